// File: doc/BRIEF.md
# SPI Status and Error Flag Unit

This unit keeps the operating state and the error flags of an SPI controller. Two state bits live here: an enable bit that moves the controller between a configuration mode (cleared) and an active mode (set), and a master-select bit. Six sticky error flags cover mode errors, transmit and receive overflow, abort, and transmit and receive underflow. A busy indication from the shift engine is passed through into the status word.

Software never writes these bits directly. It writes a command word in which every bit owns one action: set one flag, or clear one flag. Bits that are zero in the command leave their flags alone, so no read-modify-write is needed. The shift engine and the FIFOs report error events on a separate input. Each event sets its flag only when its error-enable bit is on. The one exception is the mode error, which has no enable. Any flag that is set and unmasked drives a level interrupt. That interrupt stays high until software clears the flag.

Top module: `spi_status_unit`

## Requirements
- R1: After a synchronous active-low reset, status_word reads 0x0000 when busy_in is low, active_mode is 0 (configuration mode) and err_irq is 0.
- R2: Command bit 1 sets the enable bit (status bit 0, also driven on active_mode) and command bit 0 clears it, effective in the status one clock after the write.
- R3: Command bit 3 sets the master-select bit (status bit 1) and command bit 2 clears it.
- R4: Each error flag has its own clear and set command bit. The pairs are given as clear/set, with the status bit after the arrow: mode error 6/7 -> bit 7; transmit overflow 8/12 -> bit 8; receive overflow 9/13 -> bit 9; abort 10/14 -> bit 10; transmit underflow 11/15 -> bit 11; receive underflow 4/5 -> bit 12.
- R5: When the set bit and the clear bit of one flag are written together, that flag keeps its previous value.
- R6: A pulse on hw_evt sets the matching flag one clock later, but only when that flag's gate is on. hw_evt and irq_mask both use this bit order: [0] mode error, [1] transmit overflow, [2] receive overflow, [3] abort, [4] transmit underflow, [5] receive underflow. The gate bits are err_en[0] transmit overflow, err_en[1] receive overflow, err_en[2] abort, err_en[3] transmit underflow and err_en[4] receive underflow. The mode error event is always gated on.
- R7: A gated hardware event wins over a clear command for the same flag in the same cycle, so the flag ends up set.
- R8: The command word 0x0F50 clears all six error flags in one write and leaves the enable and master-select bits unchanged.
- R9: err_irq is high exactly while at least one error flag is set whose irq_mask bit is 1. It stays high for as long as that flag remains set.
- R10: Status bit 13 follows busy_in. Status bits 2 to 6, 14 and 15 always read 0.
- R11: When cmd_we is low, cmd_data has no effect on any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Command word of paired set and clear bits |
| err_en | input | 5 | Error-source gates, order given in R6 |
| hw_evt | input | 6 | One-cycle error events from the shift engine and FIFOs |
| busy_in | input | 1 | Busy indication from the shift engine |
| irq_mask | input | 6 | Interrupt mask per flag, order given in R6 |
| status_word | output | 16 | Packed status |
| active_mode | output | 1 | 1 in active mode, 0 in configuration mode |
| err_irq | output | 1 | Level error interrupt |

## Verification
The command path is exercised three ways. Each flag is walked on its own through its set bit and its clear bit, which exposes any swapped or misplaced bit position. Set and clear are then written together to show that the flag holds its value. Finally the bulk word 0x0F50 is written, which has to clear all six flags while the enable and master-select bits stay as they were. The event path is run with every gate off and then with every gate on, so an ungated source would show up, and so would the mode error if it failed to set without a gate. An event is also issued in the same cycle as a clear of its flag, which checks that the event wins. The interrupt is checked with the mask closed and with it open, held over several cycles, and again after the flag is cleared.

// File: rtl/spi_status_pkg.sv
// Shared constants for the SPI status unit.
// Error-flag index order: 0 mode, 1 tx overflow, 2 rx overflow, 3 abort,
// 4 tx underflow, 5 rx underflow. Software decodes the bit positions
// below, so they are fixed.
package spi_status_pkg;
    localparam int NUM_ERR    = 6;
    localparam int CMD_W      = 16;
    localparam int STAT_W     = 16;
    localparam int EN_CLR     = 0;
    localparam int EN_SET     = 1;
    localparam int MS_CLR     = 2;
    localparam int MS_SET     = 3;
    localparam int STAT_EN    = 0;
    localparam int STAT_MS    = 1;
    localparam int STAT_BUSY  = 13;
    localparam int STAT_ERR0  = 7;

    // Command bit that clears error flag i
    function automatic int err_clr_pos(input int i);
        case (i)
            0:       return 6;
            1:       return 8;
            2:       return 9;
            3:       return 10;
            4:       return 11;
            default: return 4;
        endcase
    endfunction

    // Command bit that sets error flag i
    function automatic int err_set_pos(input int i);
        case (i)
            0:       return 7;
            1:       return 12;
            2:       return 13;
            3:       return 14;
            4:       return 15;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/spi_stat_cmd_decode.sv
// Splits a command write into per-bit set and clear strobes.
// Assumes cmd_data is only meaningful while cmd_we is high.
module spi_stat_cmd_decode
    import spi_status_pkg::*;
(
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              en_set,
    output logic              en_clr,
    output logic              ms_set,
    output logic              ms_clr,
    output logic [NUM_ERR-1:0] err_set,
    output logic [NUM_ERR-1:0] err_clr
);
    // State-bit strobes, qualified by the write strobe
    always_comb begin
        en_set = cmd_we & cmd_data[EN_SET];
        en_clr = cmd_we & cmd_data[EN_CLR];
        ms_set = cmd_we & cmd_data[MS_SET];
        ms_clr = cmd_we & cmd_data[MS_CLR];
    end

    // Error-flag strobes from the per-flag bit positions
    always_comb begin
        for (int i = 0; i < NUM_ERR; i++) begin
            err_set[i] = cmd_we & cmd_data[err_set_pos(i)];
            err_clr[i] = cmd_we & cmd_data[err_clr_pos(i)];
        end
    end
endmodule

// File: rtl/spi_stat_flag_bit.sv
// One sticky status bit. Priority: hardware set, then a lone command set
// or a lone command clear. Set and clear together leave the bit as it was.
module spi_stat_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic cmd_set,
    input  logic cmd_clr,
    output logic q
);
    // Bit update with hardware-first priority
    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= 1'b0;
        else if (hw_set)            q <= 1'b1;
        else if (cmd_set && !cmd_clr) q <= 1'b1;
        else if (cmd_clr && !cmd_set) q <= 1'b0;
    end

    // R4
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_set && !cmd_clr) |=> q);
    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr && !cmd_set && !hw_set) |=> !q);
    // R5
    pair_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_set && cmd_clr && !hw_set) |=> (q == $past(q)));
    // R7
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q);
endmodule

// File: rtl/spi_stat_pack.sv
// Packs state bits, error flags and busy into the software status word.
// Unused positions read zero.
module spi_stat_pack
    import spi_status_pkg::*;
(
    input  logic               en,
    input  logic               ms,
    input  logic               busy,
    input  logic [NUM_ERR-1:0] flags,
    output logic [STAT_W-1:0]  word
);
    // Place every field at its fixed position
    always_comb begin
        word            = '0;
        word[STAT_EN]   = en;
        word[STAT_MS]   = ms;
        word[STAT_BUSY] = busy;
        for (int i = 0; i < NUM_ERR; i++)
            word[STAT_ERR0 + i] = flags[i];
    end
endmodule

// File: rtl/spi_status_unit.sv
// Status and error flag unit of an SPI controller.
// All state changes come from paired set/clear command bits or from gated
// hardware events. Assumes hw_evt pulses are synchronous to clk.
module spi_status_unit
    import spi_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_data,
    input  logic [4:0]        err_en,
    input  logic [5:0]        hw_evt,
    input  logic              busy_in,
    input  logic [5:0]        irq_mask,
    output logic [15:0]       status_word,
    output logic              active_mode,
    output logic              err_irq
);
    logic               en_set, en_clr, ms_set, ms_clr;
    logic [NUM_ERR-1:0] err_set, err_clr, gate, hw_gated, flags;
    logic               en_q, ms_q;

    spi_stat_cmd_decode u_dec (
        .cmd_we  (cmd_we),
        .cmd_data(cmd_data),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .ms_set  (ms_set),
        .ms_clr  (ms_clr),
        .err_set (err_set),
        .err_clr (err_clr)
    );

    // Mode error has no enable; the others use err_en
    always_comb begin
        gate     = {err_en, 1'b1};
        hw_gated = hw_evt & gate;
    end

    spi_stat_flag_bit u_en (
        .clk(clk), .rst_n(rst_n), .hw_set(1'b0),
        .cmd_set(en_set), .cmd_clr(en_clr), .q(en_q)
    );

    spi_stat_flag_bit u_ms (
        .clk(clk), .rst_n(rst_n), .hw_set(1'b0),
        .cmd_set(ms_set), .cmd_clr(ms_clr), .q(ms_q)
    );

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
        spi_stat_flag_bit u_flag (
            .clk(clk), .rst_n(rst_n), .hw_set(hw_gated[g]),
            .cmd_set(err_set[g]), .cmd_clr(err_clr[g]), .q(flags[g])
        );
    end

    spi_stat_pack u_pack (
        .en   (en_q),
        .ms   (ms_q),
        .busy (busy_in),
        .flags(flags),
        .word (status_word)
    );

    // Level interrupt from masked flags
    always_comb begin
        active_mode = en_q;
        err_irq     = |(flags & irq_mask);
    end

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && hw_evt == '0) |=> ($stable(flags) && $stable(en_q) && $stable(ms_q)));
    // R8
    bulk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data == 16'h0F50 && hw_evt == '0)
        |=> (flags == '0 && en_q == $past(en_q) && ms_q == $past(ms_q)));
    // R6
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && hw_evt[1] && !err_en[0] && !flags[1]) |=> !flags[1]);
endmodule

// File: tb/spi_status_unit_test.sv
module spi_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [4:0]  err_en = '0;
    logic [5:0]  hw_evt = '0;
    logic        busy_in = 1'b0;
    logic [5:0]  irq_mask = '0;
    logic [15:0] status_word;
    logic        active_mode;
    logic        err_irq;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_status_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .err_en(err_en), .hw_evt(hw_evt), .busy_in(busy_in),
        .irq_mask(irq_mask), .status_word(status_word),
        .active_mode(active_mode), .err_irq(err_irq)
    );

    // Expected positions per flag, index order of R6
    function automatic int exp_clr(input int i);
        int t[6] = '{6, 8, 9, 10, 11, 4};
        return t[i];
    endfunction
    function automatic int exp_set(input int i);
        int t[6] = '{7, 12, 13, 14, 15, 5};
        return t[i];
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_cmd(input logic [15:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = d;
        @(negedge clk);
        cmd_we = 1'b0; cmd_data = '0;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        @(negedge clk);
        hw_evt = e;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_word, 16'h0000);
        chk("R1 active", {15'b0, active_mode}, 16'h0);
        chk("R1 irq", {15'b0, err_irq}, 16'h0);
    endtask

    task automatic t_enable;
        do_cmd(16'h0002);
        chk("R2 set", status_word, 16'h0001);
        chk("R2 active", {15'b0, active_mode}, 16'h1);
        do_cmd(16'h0001);
        chk("R2 clr", status_word, 16'h0000);
    endtask

    task automatic t_master;
        do_cmd(16'h0008);
        chk("R3 set", status_word, 16'h0002);
        do_cmd(16'h0004);
        chk("R3 clr", status_word, 16'h0000);
    endtask

    task automatic t_flag_cmds;
        for (int i = 0; i < 6; i++) begin
            do_cmd(16'(1 << exp_set(i)));
            chk("R4 set", status_word, 16'(1 << (7 + i)));
            do_cmd(16'(1 << exp_clr(i)));
            chk("R4 clr", status_word, 16'h0000);
        end
    endtask

    task automatic t_pair;
        do_cmd(16'h0080);
        do_cmd(16'h00C0);
        chk("R5 hold set", status_word, 16'h0080);
        do_cmd(16'h0040);
        do_cmd(16'h00C0);
        chk("R5 hold clr", status_word, 16'h0000);
    endtask

    task automatic t_gating;
        err_en = 5'b00000;
        for (int i = 0; i < 6; i++) pulse_evt(6'(1 << i));
        chk("R6 gates off", status_word, 16'h0080);
        do_cmd(16'h0F50);
        err_en = 5'b11111;
        for (int i = 0; i < 6; i++) begin
            pulse_evt(6'(1 << i));
            chk("R6 gates on", status_word, 16'(1 << (7 + i)));
            do_cmd(16'h0F50);
        end
    endtask

    task automatic t_evt_vs_clr;
        err_en = 5'b11111;
        do_cmd(16'h1000);
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = 16'h0100; hw_evt = 6'b000010;
        @(negedge clk);
        cmd_we = 1'b0; cmd_data = '0; hw_evt = '0;
        chk("R7 event wins", status_word, 16'h0100);
        do_cmd(16'h0F50);
    endtask

    task automatic t_bulk;
        do_cmd(16'h000A);
        do_cmd(16'hF0A0);
        chk("R8 all set", status_word, 16'h1F83);
        do_cmd(16'h0F50);
        chk("R8 bulk clr", status_word, 16'h0003);
        do_cmd(16'h0005);
    endtask

    task automatic t_irq;
        irq_mask = 6'b000000;
        do_cmd(16'h2000);
        chk("R9 masked", {15'b0, err_irq}, 16'h0);
        irq_mask = 6'b000100;
        @(negedge clk);
        chk("R9 unmasked", {15'b0, err_irq}, 16'h1);
        repeat (4) @(negedge clk);
        chk("R9 held", {15'b0, err_irq}, 16'h1);
        do_cmd(16'h0200);
        chk("R9 cleared", {15'b0, err_irq}, 16'h0);
        irq_mask = '0;
    endtask

    task automatic t_busy;
        busy_in = 1'b1;
        @(negedge clk);
        chk("R10 busy", status_word, 16'h2000);
        busy_in = 1'b0;
        @(negedge clk);
        chk("R10 idle", status_word, 16'h0000);
    endtask

    task automatic t_ignore;
        do_cmd(16'h0082);
        @(negedge clk);
        cmd_we = 1'b0; cmd_data = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        cmd_data = '0;
        chk("R11 no write", status_word, 16'h0081);
        do_cmd(16'h0041);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable;
        t_master;
        t_flag_cmds;
        t_pair;
        t_gating;
        t_evt_vs_clr;
        t_bulk;
        t_irq;
        t_busy;
        t_ignore;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=%h exp=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule